// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block evaluates a set of Boolean functions of a small group of input variables through two programmable planes. The first plane builds a shared pool of product terms, where each term says, for every input variable, whether it needs the true form, the complement, or does not look at it. The second plane ORs any chosen subset of those terms into each output. Because a term can feed any number of outputs, the array is sized by the number of distinct terms the whole function set needs, not by the count per function.

The personality sits in registers. A synchronous write port loads one product term per clock cycle: its literal codes and the column mask that says which outputs it drives. Evaluation is purely combinational from the input variables and the stored personality, so the array behaves like a 2^n by m-bit lookup of the programmed functions. The default size is 3 inputs, 5 product terms and 4 outputs. All three are parameters.

Top module: `pla_array`

## Requirements
- R1: A synchronous active-high reset clears every literal code to 00 and every column mask to zero, so all outputs read 0 for every input value until a term is written.
- R2: When `cfg_we` is high at a rising clock edge, term `cfg_idx` takes `cfg_data` at that edge. The new personality shows at the outputs after that edge and not before it. With `cfg_we` low, the personality does not change.
- R3: Literal code 01 in the 2-bit field `cfg_data[2i+1:2i]` makes the term require input variable i to be 1.
- R4: Literal code 10 makes the term require input variable i to be 0.
- R5: Literal code 00 leaves input variable i out of the term. A term whose fields are all 00 is always 1.
- R6: Literal code 11 forces the term to 0, whatever the inputs are.
- R7: Output j is the OR of all terms whose column mask bit `cfg_data[2*N_IN+j]` is 1. An output with no selected terms is 0.
- R8: One product term can drive several outputs at once through its column mask.
- R9: A write whose `cfg_idx` is N_TERM or greater changes nothing.
- R10: The outputs follow a change on `in_vars` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for one product term |
| cfg_idx | input | IDX_W | Product term to write |
| cfg_data | input | 2*N_IN+N_OUT | Literal codes (low bits, 2 per input) and column mask (high bits) |
| in_vars | input | N_IN | Input variables |
| out_funcs | output | N_OUT | Programmed function outputs |

## Verification
The assertions take for granted that `cfg_we`, `cfg_idx` and `cfg_data` are known at each rising edge, and that `in_vars` only changes between edges. The hold and out-of-range properties compare outputs across two edges only when the inputs were stable across them. The bench therefore drives all configuration fields on the falling edge. It sweeps every input combination inside the low half of the clock, so each check sits between edges. It also ends each sweep on a fixed value before the next edge.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        LIT_ANY  = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_NONE = 2'b11
    } lit_code_e;

    // Contribution of one literal to its product term.
    function automatic logic lit_pass(input lit_code_e code, input logic v);
        logic r;
        case (code)
            LIT_ANY:  r = 1'b1;
            LIT_POS:  r = v;
            LIT_NEG:  r = ~v;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic int idx_width(input int terms);
        return (terms > 1) ? $clog2(terms) : 1;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int IDX_W  = 3,
    parameter int LIT_W  = 2 * N_IN,
    parameter int CFG_W  = LIT_W + N_OUT
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [CFG_W-1:0]                    data,
    output logic [N_TERM-1:0][LIT_W-1:0]        and_cfg,
    output logic [N_TERM-1:0][N_OUT-1:0]        or_cfg
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic hit;
        assign hit = we && (idx == IDX_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                and_cfg[t] <= '0;
                or_cfg[t]  <= '0;
            end else if (hit) begin
                and_cfg[t] <= data[LIT_W-1:0];
                or_cfg[t]  <= data[CFG_W-1:LIT_W];
            end
        end
    end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int LIT_W  = 2 * N_IN
) (
    input  logic [N_IN-1:0]                 in_vars,
    input  logic [N_TERM-1:0][LIT_W-1:0]    and_cfg,
    output logic [N_TERM-1:0]               terms
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        always_comb begin
            logic acc;
            acc = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                acc = acc & lit_pass(lit_code_e'(and_cfg[t][2*i +: 2]), in_vars[i]);
            end
            terms[t] = acc;
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4
) (
    input  logic [N_TERM-1:0]               terms,
    input  logic [N_TERM-1:0][N_OUT-1:0]    or_cfg,
    output logic [N_OUT-1:0]                outs
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_TERM-1:0] column;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign column[t] = or_cfg[t][j];
        end
        assign outs[j] = |(terms & column);
    end

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int IDX_W  = idx_width(N_TERM),
    parameter int CFG_W  = 2 * N_IN + N_OUT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [N_IN-1:0]   in_vars,
    output logic [N_OUT-1:0]  out_funcs
);

    localparam int LIT_W = 2 * N_IN;

    logic [N_TERM-1:0][LIT_W-1:0] and_cfg;
    logic [N_TERM-1:0][N_OUT-1:0] or_cfg;
    logic [N_TERM-1:0]            terms;

    pla_cfg_store #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT),
        .IDX_W(IDX_W), .LIT_W(LIT_W), .CFG_W(CFG_W)
    ) store_i (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .data(cfg_data),
        .and_cfg(and_cfg), .or_cfg(or_cfg)
    );

    pla_and_plane #(
        .N_IN(N_IN), .N_TERM(N_TERM), .LIT_W(LIT_W)
    ) and_i (
        .in_vars(in_vars), .and_cfg(and_cfg), .terms(terms)
    );

    pla_or_plane #(
        .N_TERM(N_TERM), .N_OUT(N_OUT)
    ) or_i (
        .terms(terms), .or_cfg(or_cfg), .outs(out_funcs)
    );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    parameter int IDX_W  = 3,
    parameter int CFG_W  = 2 * N_IN + N_OUT
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [CFG_W-1:0]  cfg_data,
    input logic [N_IN-1:0]   in_vars,
    input logic [N_OUT-1:0]  out_funcs
);

    localparam int LIT_W = 2 * N_IN;
    localparam logic [CFG_W-1:0] ALL_ON = {{N_OUT{1'b1}}, {LIT_W{1'b0}}};

    // R1: the cycle after reset, every output is 0.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_funcs == '0));

    // R2: no write and steady inputs keep the outputs steady.
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we) && $stable(in_vars)) |-> $stable(out_funcs));

    // R9: a write to an index past the last term has no effect.
    p_bad_idx_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we) && ($past(cfg_idx) >= N_TERM) && $stable(in_vars))
        |-> $stable(out_funcs));

    // R5 / R7: an all-absent term sent to every output drives them all to 1.
    p_all_on_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we) && ($past(cfg_idx) < N_TERM) && ($past(cfg_data) == ALL_ON))
        |-> (&out_funcs));

endmodule

bind pla_array pla_array_chk #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .IDX_W(IDX_W), .CFG_W(CFG_W)
) chk_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .in_vars(in_vars), .out_funcs(out_funcs)
);

// File: tb/pla_array_tb_top.sv
`timescale 1ns/1ps
module pla_array_tb_top;

    localparam int N_IN   = 3;
    localparam int N_TERM = 5;
    localparam int N_OUT  = 4;
    localparam int IDX_W  = 3;
    localparam int LIT_W  = 2 * N_IN;
    localparam int CFG_W  = LIT_W + N_OUT;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [CFG_W-1:0]  cfg_data = '0;
    logic [N_IN-1:0]   in_vars = '0;
    logic [N_OUT-1:0]  out_funcs;

    int n_chk = 0;
    int n_bad = 0;

    logic [LIT_W-1:0] lit_m  [N_TERM];
    logic [N_OUT-1:0] mask_m [N_TERM];

    always #2 clk = ~clk;

    pla_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .in_vars(in_vars), .out_funcs(out_funcs)
    );

    function automatic logic [N_OUT-1:0] model_eval(input logic [N_IN-1:0] x);
        logic [N_OUT-1:0] r = '0;
        for (int t = 0; t < N_TERM; t++) begin
            logic p = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                logic [1:0] c = lit_m[t][2*i +: 2];
                if (c == 2'b01) p = p & x[i];
                else if (c == 2'b10) p = p & ~x[i];
                else if (c == 2'b11) p = 1'b0;
            end
            if (p) r = r | mask_m[t];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s in=%b actual=%b expected=%b", req, in_vars, act, exp);
        end
    endtask

    // Sweep every input value inside the low clock phase.
    task automatic sweep(input string req);
        for (int x = 0; x < (1 << N_IN); x++) begin
            in_vars = N_IN'(x);
            #0.1;
            check(req, out_funcs, model_eval(N_IN'(x)));
        end
        in_vars = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int t = 0; t < N_TERM; t++) begin
            lit_m[t] = '0;
            mask_m[t] = '0;
        end
    endtask

    task automatic write_term(input int idx, input logic [LIT_W-1:0] lits, input logic [N_OUT-1:0] mask);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_idx  = IDX_W'(idx);
        cfg_data = {mask, lits};
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < N_TERM) begin
            lit_m[idx]  = lits;
            mask_m[idx] = mask;
        end
    endtask

    function automatic logic [LIT_W-1:0] rand_lits();
        logic [LIT_W-1:0] l;
        for (int i = 0; i < N_IN; i++) begin
            int r = $urandom_range(0, 9);
            l[2*i +: 2] = (r == 9) ? 2'b11 : 2'(r % 3);
        end
        return l;
    endfunction

    initial begin
        #(4.0 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        @(negedge clk);
        // R1: cleared personality, every output 0
        for (int x = 0; x < (1 << N_IN); x++) begin
            in_vars = N_IN'(x);
            #0.1;
            check("R1", out_funcs, '0);
        end

        // R3: term0 = x0, to out0
        write_term(0, 6'b00_00_01, 4'b0001);
        sweep("R3");
        // R4: term1 = ~x1, to out1
        write_term(1, 6'b00_10_00, 4'b0010);
        sweep("R4");
        // R6: term2 has x2 code 11, to out2, so out2 stays 0
        write_term(2, 6'b11_00_00, 4'b0100);
        sweep("R6");
        // R5: term3 all absent, to out3, so out3 is 1
        write_term(3, 6'b00_00_00, 4'b1000);
        sweep("R5");
        // R8: term4 = x2 & ~x0 drives out0, out1 and out2
        write_term(4, 6'b01_00_10, 4'b0111);
        sweep("R8");
        // R7: out0 = x0 | (x2 & ~x0); clear term3 mask: out3 has no terms
        write_term(3, 6'b00_00_00, 4'b0000);
        sweep("R7");

        // R9: writes past the last term leave all outputs as they were
        for (int k = N_TERM; k < (1 << IDX_W); k++) begin
            write_term(k, 6'b00_00_00, 4'b1111);
        end
        sweep("R9");

        // R2: data on the bus with the enable low changes nothing
        @(negedge clk);
        cfg_idx  = 3'd0;
        cfg_data = {4'b1111, 6'b00_00_00};
        @(negedge clk);
        sweep("R2");
        // R2: enabled write is not visible before the edge, visible after
        cfg_we = 1'b1;
        cfg_idx = 3'd3;
        cfg_data = {4'b1000, 6'b00_00_00};
        in_vars = 3'b000;
        #0.5;
        check("R2", out_funcs, model_eval(3'b000));
        @(negedge clk);
        cfg_we = 1'b0;
        lit_m[3] = 6'b00_00_00;
        mask_m[3] = 4'b1000;
        sweep("R2");

        // R10: outputs follow input changes with no clock edge between
        @(negedge clk);
        in_vars = 3'b001;
        #0.3;
        check("R10", out_funcs, model_eval(3'b001));
        in_vars = 3'b100;
        #0.3;
        check("R10", out_funcs, model_eval(3'b100));
        in_vars = '0;

        // R7: random personalities against the sum-of-products model
        for (int p = 0; p < 40; p++) begin
            for (int t = 0; t < N_TERM; t++) begin
                write_term(t, rand_lits(), N_OUT'($urandom));
            end
            @(negedge clk);
            sweep("R7");
        end

        // R1: reset again after a full personality
        do_reset();
        @(negedge clk);
        sweep("R1");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule